// File: doc/BRIEF.md
# Floating-Point Operate Word Decoder

This block accepts 32-bit floating-point operate instruction words on a valid/ready input stream and returns, one word at a time on a valid/ready output stream, a decoded record for each. The record tells whether the word is a recognised arithmetic-class or compare-class operation. It gives the 9-bit operation field, a packed descriptor of the precision and pack flag for each of the three operands, and the three register indices. It also gives an invalid-register fault with the trap-type value to be merged into the floating-point status register.

Decoding is purely combinational from the input word. A single register stage sits behind the input handshake, so a decoded record appears on the output one cycle after the word is accepted. On the input side, `in_ready` is high whenever the output stage is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). When `out_valid` is high and `out_ready` is low, the whole output record holds unchanged and no new word is taken. A producer must keep `in_valid` and `in_word` steady until the word is accepted. The block does not perform the arithmetic, does not read the register file and does not handle trap queues.

Top module: `fpop_decoder`

## Requirements
- R1: A word is arithmetic-class when `(word & 32'hC1F80000) == 32'h81A00000` and compare-class when the masked value is `32'h81A80000`. Any other word is unrecognised, and an unrecognised word gives `out_known`=0, `out_desc`=0, `out_opf`=0, `out_is_cmp`=0 and `out_fault`=0.
- R2: Fields are taken as opf = bits 13:5, rd = bits 29:25, rs1 = bits 18:14 and rs2 = bits 4:0. When the word is recognised, `out_opf` equals opf.
- R3: Descriptor layout: rs1 size in bits 1:0 with its pack flag in bit 2, rs2 size in bits 4:3 with its pack flag in bit 5, and rd size in bits 7:6 with its pack flag in bit 8. Sizes are encoded 0 none, 1 single, 2 double, 3 quad. Entries below are written as rd/rs2/rs1, with the pack flag 1 unless marked u.
- R4: Arithmetic-class two-source entries: add/sub/mul/div single 041/045/049/04D are S/S/S, double 042/046/04A/04E are D/D/D, and quad 043/047/04B/04F are Q/Q/Q. The widening multiplies are 069 D/S/S and 06E Q/D/D.
- R5: Arithmetic-class one-source entries (rs1 none): square root 029 S/S, 02A D/D, 02B Q/Q. Conversions: 0C6 S/D, 0C7 S/Q, 0C9 D/S, 0CB D/Q, 0CD Q/S, 0CE Q/D, 0C4 S/Su, 0C8 D/Su, 0CC Q/Su, 0D1 Su/S, 0D2 Su/D, 0D3 Su/Q.
- R6: Move 001, negate 005 and absolute 009 are arithmetic-class Su/Su with rs1 none. Compare-class entries have rd none with flag 0: 051/055 -/S/S, 052/056 -/D/D, 053/057 -/Q/Q. `out_is_cmp` is 1 exactly for recognised compare-class words.
- R7: An opcode recognised in one class but presented in the other class is unrecognised.
- R8: Each operand whose size is quad must have index bits 1:0 zero, and each operand whose size is double must have bit 0 zero. A violation sets `out_fault`=1 and `out_trap`=6. Otherwise `out_trap`=0.
- R9: For a compare-class word, a nonzero rd field is a fault with `out_trap`=6. An operand of size none other than the compare destination is never checked.
- R10: When the word is unrecognised or faulted, `out_rs1`, `out_rs2` and `out_rd` are 0. Otherwise they equal the word's fields.
- R11: `in_ready = !out_valid || out_ready`. A word accepted in cycle n is presented with `out_valid`=1 in cycle n+1. While `out_valid`=1 and `out_ready`=0, all outputs stay stable.
- R12: During and right after reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_word | input | 32 | Floating-point operate instruction word |
| out_valid | output | 1 | Decoded record valid |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_known | output | 1 | Word matched a table entry |
| out_is_cmp | output | 1 | Recognised compare-class word |
| out_opf | output | 9 | Operation field, 0 when unrecognised |
| out_desc | output | 9 | Packed per-operand size/pack descriptor |
| out_rs1 | output | 5 | First source index (0 on fault/unknown) |
| out_rs2 | output | 5 | Second source index (0 on fault/unknown) |
| out_rd | output | 5 | Destination index (0 on fault/unknown) |
| out_fault | output | 1 | Invalid-register fault |
| out_trap | output | 3 | Trap type for the status register (6 on fault) |

## Verification
Every decoded field is due exactly one cycle after the word's acceptance edge, and nothing is ever due earlier. The bench therefore sets its inputs after the falling edge and reads the handshake a moment later. It queues a reference record on each accepted word and compares a record only in a cycle where `out_valid` and `out_ready` are both high. In each cycle that follows a stalled output, the bench also compares the whole record with the previous cycle's record, which exercises the hold rule under random back-pressure.

// File: rtl/fpop_pkg.sv
package fpop_pkg;

  localparam int WORD_W  = 32;
  localparam int REG_W   = 5;
  localparam int OPF_W   = 9;
  localparam int TRAP_W  = 3;
  localparam int NOPND   = 3;

  localparam logic [WORD_W-1:0] CLASS_MASK = 32'hC1F8_0000;
  localparam logic [WORD_W-1:0] ARITH_VAL  = 32'h81A0_0000;
  localparam logic [WORD_W-1:0] CMP_VAL    = 32'h81A8_0000;
  localparam logic [TRAP_W-1:0] TRAP_BAD_REG = 3'd6;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_SGL  = 2'd1,
    SZ_DBL  = 2'd2,
    SZ_QUAD = 2'd3
  } opsize_e;

  typedef struct packed {
    logic    pk;
    opsize_e sz;
  } opnd_t;

  typedef struct packed {
    opnd_t rd;
    opnd_t rs2;
    opnd_t rs1;
  } desc_t;

  localparam desc_t DESC_NONE = '0;

  typedef struct packed {
    logic              known;
    logic              is_cmp;
    logic [OPF_W-1:0]  opf;
    desc_t             desc;
    logic              fault;
    logic [TRAP_W-1:0] trap;
    logic [REG_W-1:0]  rs1;
    logic [REG_W-1:0]  rs2;
    logic [REG_W-1:0]  rd;
  } dec_t;

  function automatic desc_t mk(opsize_e dsz, logic dpk, opsize_e bsz, logic bpk,
                               opsize_e asz, logic apk);
    desc_t d;
    d.rd.sz  = dsz;
    d.rd.pk  = dpk;
    d.rs2.sz = bsz;
    d.rs2.pk = bpk;
    d.rs1.sz = asz;
    d.rs1.pk = apk;
    return d;
  endfunction

endpackage

// File: rtl/fpop_opcode_table.sv
module fpop_opcode_table
  import fpop_pkg::*;
(
  input  logic             cls_arith,
  input  logic             cls_cmp,
  input  logic [OPF_W-1:0] opf,
  output desc_t            desc
);

  desc_t arith_d;
  desc_t cmp_d;

  // Arithmetic-class table (R4, R5, R6)
  always_comb begin
    case (opf)
      9'h041, 9'h045, 9'h049, 9'h04D: arith_d = mk(SZ_SGL,  1'b1, SZ_SGL,  1'b1, SZ_SGL,  1'b1);
      9'h042, 9'h046, 9'h04A, 9'h04E: arith_d = mk(SZ_DBL,  1'b1, SZ_DBL,  1'b1, SZ_DBL,  1'b1);
      9'h043, 9'h047, 9'h04B, 9'h04F: arith_d = mk(SZ_QUAD, 1'b1, SZ_QUAD, 1'b1, SZ_QUAD, 1'b1);
      9'h069: arith_d = mk(SZ_DBL,  1'b1, SZ_SGL,  1'b1, SZ_SGL,  1'b1);
      9'h06E: arith_d = mk(SZ_QUAD, 1'b1, SZ_DBL,  1'b1, SZ_DBL,  1'b1);
      9'h029: arith_d = mk(SZ_SGL,  1'b1, SZ_SGL,  1'b1, SZ_NONE, 1'b0);
      9'h02A: arith_d = mk(SZ_DBL,  1'b1, SZ_DBL,  1'b1, SZ_NONE, 1'b0);
      9'h02B: arith_d = mk(SZ_QUAD, 1'b1, SZ_QUAD, 1'b1, SZ_NONE, 1'b0);
      9'h0C6: arith_d = mk(SZ_SGL,  1'b1, SZ_DBL,  1'b1, SZ_NONE, 1'b0);
      9'h0C7: arith_d = mk(SZ_SGL,  1'b1, SZ_QUAD, 1'b1, SZ_NONE, 1'b0);
      9'h0C9: arith_d = mk(SZ_DBL,  1'b1, SZ_SGL,  1'b1, SZ_NONE, 1'b0);
      9'h0CB: arith_d = mk(SZ_DBL,  1'b1, SZ_QUAD, 1'b1, SZ_NONE, 1'b0);
      9'h0CD: arith_d = mk(SZ_QUAD, 1'b1, SZ_SGL,  1'b1, SZ_NONE, 1'b0);
      9'h0CE: arith_d = mk(SZ_QUAD, 1'b1, SZ_DBL,  1'b1, SZ_NONE, 1'b0);
      9'h0C4: arith_d = mk(SZ_SGL,  1'b1, SZ_SGL,  1'b0, SZ_NONE, 1'b0);
      9'h0C8: arith_d = mk(SZ_DBL,  1'b1, SZ_SGL,  1'b0, SZ_NONE, 1'b0);
      9'h0CC: arith_d = mk(SZ_QUAD, 1'b1, SZ_SGL,  1'b0, SZ_NONE, 1'b0);
      9'h0D1: arith_d = mk(SZ_SGL,  1'b0, SZ_SGL,  1'b1, SZ_NONE, 1'b0);
      9'h0D2: arith_d = mk(SZ_SGL,  1'b0, SZ_DBL,  1'b1, SZ_NONE, 1'b0);
      9'h0D3: arith_d = mk(SZ_SGL,  1'b0, SZ_QUAD, 1'b1, SZ_NONE, 1'b0);
      9'h001, 9'h005, 9'h009:
              arith_d = mk(SZ_SGL,  1'b0, SZ_SGL,  1'b0, SZ_NONE, 1'b0);
      default: arith_d = DESC_NONE;
    endcase
  end

  // Compare-class table: destination is the condition code (R6)
  always_comb begin
    case (opf)
      9'h051, 9'h055: cmp_d = mk(SZ_NONE, 1'b0, SZ_SGL,  1'b1, SZ_SGL,  1'b1);
      9'h052, 9'h056: cmp_d = mk(SZ_NONE, 1'b0, SZ_DBL,  1'b1, SZ_DBL,  1'b1);
      9'h053, 9'h057: cmp_d = mk(SZ_NONE, 1'b0, SZ_QUAD, 1'b1, SZ_QUAD, 1'b1);
      default:        cmp_d = DESC_NONE;
    endcase
  end

  // Class picks the table, so an opcode in the wrong class misses (R7)
  always_comb begin
    if (cls_arith)    desc = arith_d;
    else if (cls_cmp) desc = cmp_d;
    else              desc = DESC_NONE;
  end

endmodule

// File: rtl/fpop_reg_align.sv
module fpop_reg_align
  import fpop_pkg::*;
(
  input  desc_t            desc,
  input  logic [REG_W-1:0] rs1,
  input  logic [REG_W-1:0] rs2,
  input  logic [REG_W-1:0] rd,
  output logic             bad
);

  localparam int DST = NOPND - 1;

  opnd_t            ops [NOPND];
  logic [REG_W-1:0] idx [NOPND];
  logic [NOPND-1:0] bad_v;

  assign ops[0] = desc.rs1;
  assign ops[1] = desc.rs2;
  assign ops[2] = desc.rd;
  assign idx[0] = rs1;
  assign idx[1] = rs2;
  assign idx[2] = rd;

  for (genvar g = 0; g < NOPND; g++) begin : g_op
    logic misal;
    always_comb begin
      case (ops[g].sz)
        SZ_QUAD: misal = |idx[g][1:0];
        SZ_DBL:  misal = idx[g][0];
        default: misal = 1'b0;
      endcase
    end
    if (g == DST) begin : g_dst
      // size-none destination is the condition code: field must be zero (R9)
      assign bad_v[g] = misal || ((ops[g].sz == SZ_NONE) && (|idx[g]));
    end else begin : g_src
      assign bad_v[g] = misal;
    end
  end

  assign bad = |bad_v;

endmodule

// File: rtl/fpop_out_slice.sv
module fpop_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: rtl/fpop_decoder.sv
module fpop_decoder
  import fpop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_known,
  output logic              out_is_cmp,
  output logic [8:0]        out_opf,
  output logic [8:0]        out_desc,
  output logic [4:0]        out_rs1,
  output logic [4:0]        out_rs2,
  output logic [4:0]        out_rd,
  output logic              out_fault,
  output logic [2:0]        out_trap
);

  localparam int DEC_W = $bits(dec_t);

  // field extraction (R2)
  logic [OPF_W-1:0] f_opf;
  logic [REG_W-1:0] f_rs1, f_rs2, f_rd;
  assign f_opf = in_word[13:5];
  assign f_rs1 = in_word[18:14];
  assign f_rs2 = in_word[4:0];
  assign f_rd  = in_word[29:25];

  // class match (R1)
  logic cls_arith, cls_cmp;
  assign cls_arith = (in_word & CLASS_MASK) == ARITH_VAL;
  assign cls_cmp   = (in_word & CLASS_MASK) == CMP_VAL;

  desc_t raw_desc;
  logic  align_bad;

  fpop_opcode_table u_tbl (
    .cls_arith (cls_arith),
    .cls_cmp   (cls_cmp),
    .opf       (f_opf),
    .desc      (raw_desc)
  );

  fpop_reg_align u_align (
    .desc (raw_desc),
    .rs1  (f_rs1),
    .rs2  (f_rs2),
    .rd   (f_rd),
    .bad  (align_bad)
  );

  dec_t nxt;
  logic known, fault, pass;
  assign known = raw_desc != DESC_NONE;
  assign fault = known && align_bad;
  assign pass  = known && !fault;

  always_comb begin
    nxt.known  = known;
    nxt.is_cmp = known && cls_cmp;
    nxt.opf    = known ? f_opf : '0;
    nxt.desc   = raw_desc;
    nxt.fault  = fault;
    nxt.trap   = fault ? TRAP_BAD_REG : '0;
    nxt.rs1    = pass ? f_rs1 : '0;
    nxt.rs2    = pass ? f_rs2 : '0;
    nxt.rd     = pass ? f_rd  : '0;
  end

  logic [DEC_W-1:0] q_vec;
  dec_t             q;

  fpop_out_slice #(.W(DEC_W)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (q_vec)
  );

  assign q          = dec_t'(q_vec);
  assign out_known  = q.known;
  assign out_is_cmp = q.is_cmp;
  assign out_opf    = q.opf;
  assign out_desc   = q.desc;
  assign out_fault  = q.fault;
  assign out_trap   = q.trap;
  assign out_rs1    = q.rs1;
  assign out_rs2    = q.rs2;
  assign out_rd     = q.rd;

  a_r1_unknown_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_known) |-> (out_desc == '0 && !out_fault && out_opf == '0 && !out_is_cmp));

  a_r8_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fault ? (out_trap == TRAP_BAD_REG) : (out_trap == '0)));

  a_r10_zero_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_fault || !out_known)) |-> (out_rs1 == '0 && out_rs2 == '0 && out_rd == '0));

  a_r8_quad_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_known && !out_fault && out_desc[1:0] == 2'd3) |-> (out_rs1[1:0] == 2'b00));

  a_r9_cmp_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_cmp && !out_fault) |-> (out_rd == '0 && out_desc[7:6] == 2'd0));

endmodule

// File: tb/fpop_decoder_tb.sv
module fpop_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_valid;
  logic        out_ready;
  logic        out_known, out_is_cmp, out_fault;
  logic [8:0]  out_opf, out_desc;
  logic [4:0]  out_rs1, out_rs2, out_rd;
  logic [2:0]  out_trap;

  always #4 clk = ~clk;  // 125 MHz

  fpop_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_known(out_known), .out_is_cmp(out_is_cmp),
    .out_opf(out_opf), .out_desc(out_desc), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_rd(out_rd),
    .out_fault(out_fault), .out_trap(out_trap)
  );

  typedef struct packed {
    logic       known;
    logic       is_cmp;
    logic [8:0] opf;
    logic [8:0] desc;
    logic       fault;
    logic [2:0] trap;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [4:0] rd;
  } exp_t;

  int n_chk = 0;
  int n_bad = 0;
  localparam int NDIR = 16;
  localparam int NRND = 3000;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] td(logic [1:0] r, bit rp, logic [1:0] b, bit bp, logic [1:0] a, bit ap);
    return {rp, r, bp, b, ap, a};
  endfunction

  function automatic logic [8:0] tbl_arith(logic [8:0] op);
    case (op)
      9'h041, 9'h045, 9'h049, 9'h04D: return td(1,1,1,1,1,1);
      9'h042, 9'h046, 9'h04A, 9'h04E: return td(2,1,2,1,2,1);
      9'h043, 9'h047, 9'h04B, 9'h04F: return td(3,1,3,1,3,1);
      9'h069: return td(2,1,1,1,1,1);
      9'h06E: return td(3,1,2,1,2,1);
      9'h029: return td(1,1,1,1,0,0);
      9'h02A: return td(2,1,2,1,0,0);
      9'h02B: return td(3,1,3,1,0,0);
      9'h0C6: return td(1,1,2,1,0,0);
      9'h0C7: return td(1,1,3,1,0,0);
      9'h0C9: return td(2,1,1,1,0,0);
      9'h0CB: return td(2,1,3,1,0,0);
      9'h0CD: return td(3,1,1,1,0,0);
      9'h0CE: return td(3,1,2,1,0,0);
      9'h0C4: return td(1,1,1,0,0,0);
      9'h0C8: return td(2,1,1,0,0,0);
      9'h0CC: return td(3,1,1,0,0,0);
      9'h0D1: return td(1,0,1,1,0,0);
      9'h0D2: return td(1,0,2,1,0,0);
      9'h0D3: return td(1,0,3,1,0,0);
      9'h001, 9'h005, 9'h009: return td(1,0,1,0,0,0);
      default: return 9'h0;
    endcase
  endfunction

  function automatic logic [8:0] tbl_cmp(logic [8:0] op);
    case (op)
      9'h051, 9'h055: return td(0,0,1,1,1,1);
      9'h052, 9'h056: return td(0,0,2,1,2,1);
      9'h053, 9'h057: return td(0,0,3,1,3,1);
      default: return 9'h0;
    endcase
  endfunction

  function automatic bit misal(logic [1:0] sz, logic [4:0] r);
    return (sz == 2'd3 && r[1:0] != 2'b00) || (sz == 2'd2 && r[0]);
  endfunction

  function automatic exp_t model(logic [31:0] w);
    exp_t e;
    bit c1, c2, bad, ok;
    logic [8:0] d;
    c1 = (w & 32'hC1F80000) == 32'h81A00000;
    c2 = (w & 32'hC1F80000) == 32'h81A80000;
    d  = c1 ? tbl_arith(w[13:5]) : (c2 ? tbl_cmp(w[13:5]) : 9'h0);
    e.known  = d != 9'h0;
    e.is_cmp = e.known && c2;
    e.opf    = e.known ? w[13:5] : 9'h0;
    e.desc   = d;
    bad = misal(d[1:0], w[18:14]) || misal(d[4:3], w[4:0]) || misal(d[7:6], w[29:25]) ||
          (d[7:6] == 2'd0 && w[29:25] != 5'd0);
    e.fault = e.known && bad;
    e.trap  = e.fault ? 3'd6 : 3'd0;
    ok      = e.known && !e.fault;
    e.rs1   = ok ? w[18:14] : 5'd0;
    e.rs2   = ok ? w[4:0]   : 5'd0;
    e.rd    = ok ? w[29:25] : 5'd0;
    return e;
  endfunction

  function automatic logic [31:0] mkw(bit cmp, logic [8:0] op, logic [4:0] rd, logic [4:0] a, logic [4:0] b);
    return {2'b10, rd, (cmp ? 6'h35 : 6'h34), a, op, b};
  endfunction

  function automatic logic [8:0] op_arith(int k);
    case (k)
      0: return 9'h02B;  1: return 9'h043;  2: return 9'h047;  3: return 9'h04B;
      4: return 9'h04F;  5: return 9'h06E;  6: return 9'h0C7;  7: return 9'h0CB;
      8: return 9'h0CC;  9: return 9'h0CD; 10: return 9'h0CE; 11: return 9'h0D3;
     12: return 9'h029; 13: return 9'h02A; 14: return 9'h041; 15: return 9'h042;
     16: return 9'h045; 17: return 9'h046; 18: return 9'h049; 19: return 9'h04A;
     20: return 9'h04D; 21: return 9'h04E; 22: return 9'h069; 23: return 9'h0C6;
     24: return 9'h0C9; 25: return 9'h0D1; 26: return 9'h0D2; 27: return 9'h0C4;
     28: return 9'h0C8; 29: return 9'h001; 30: return 9'h009; default: return 9'h005;
    endcase
  endfunction

  function automatic logic [31:0] directed(int i);
    case (i)
      0:  return mkw(0, 9'h041, 5'd3,  5'd7,  5'd9);    // R4 single add, odd regs fine
      1:  return mkw(0, 9'h043, 5'd12, 5'd4,  5'd8);    // R4 quad add aligned
      2:  return mkw(0, 9'h043, 5'd12, 5'd2,  5'd8);    // R8 quad rs1 misaligned
      3:  return mkw(0, 9'h042, 5'd3,  5'd2,  5'd4);    // R8 double rd odd
      4:  return mkw(1, 9'h051, 5'd1,  5'd1,  5'd2);    // R9 compare with rd nonzero
      5:  return mkw(1, 9'h055, 5'd0,  5'd1,  5'd2);    // R6 compare single ok
      6:  return mkw(0, 9'h001, 5'd5,  5'd31, 5'd7);    // R6 move, rs1 ignored
      7:  return mkw(0, 9'h0CC, 5'd4,  5'd0,  5'd7);    // R5 int to quad
      8:  return mkw(0, 9'h0D3, 5'd1,  5'd0,  5'd6);    // R5 quad to int, rs2 misaligned
      9:  return mkw(0, 9'h051, 5'd0,  5'd1,  5'd2);    // R7 compare opcode in arith class
      10: return mkw(1, 9'h001, 5'd0,  5'd1,  5'd2);    // R7 move opcode in compare class
      11: return mkw(0, 9'h041, 5'd0,  5'd0,  5'd0) | 32'h4000_0000; // R1 class bit wrong
      12: return mkw(0, 9'h0FF, 5'd2,  5'd2,  5'd2);    // R1 unknown opf
      13: return mkw(0, 9'h02B, 5'd8,  5'd3,  5'd4);    // R5 sqrt quad, rs1 unchecked
      14: return mkw(1, 9'h057, 5'd0,  5'd4,  5'd6);    // R8 quad compare rs2 misaligned
      default: return mkw(0, 9'h06E, 5'd4, 5'd2, 5'd6); // R4 widening multiply aligned
    endcase
  endfunction

  function automatic logic [31:0] gen(int i);
    logic [31:0] w;
    int sel;
    logic [4:0] rd, a, b;
    if (i < NDIR) return directed(i);
    sel = int'($urandom % 20);
    rd = 5'($urandom); a = 5'($urandom); b = 5'($urandom);
    if ($urandom % 2 == 0) begin rd[1:0] = 2'b00; a[1:0] = 2'b00; b[1:0] = 2'b00; end
    if (sel < 12)      w = mkw(0, op_arith(int'($urandom % 32)), rd, a, b);
    else if (sel < 16) w = mkw(1, 9'h050 + 9'($urandom % 8), ($urandom % 2 == 0) ? 5'd0 : rd, a, b);
    else if (sel < 18) w = mkw($urandom % 2 == 1, 9'($urandom), rd, a, b);
    else               w = $urandom;
    return w;
  endfunction

  exp_t q[$];

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] cur;
    logic [38:0] snap;
    bit have, held, prev_hold, acc;
    int idx;
    exp_t e;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R12 out_valid in reset", 32'(out_valid), 0);
    chk(in_ready == 1'b1, "R12 in_ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R12 out_valid after reset", 32'(out_valid), 0);

    have = 0; held = 0; prev_hold = 0; idx = 0; cur = '0; snap = '0;
    while (idx < NDIR + NRND || q.size() != 0) begin
      @(negedge clk);
      if (!have && idx < NDIR + NRND) begin cur = gen(idx); have = 1; end
      in_valid  = have && (held || ($urandom % 5 != 0));
      in_word   = cur;
      out_ready = (idx >= NDIR + NRND) ? 1'b1 : ($urandom % 10 < 7);
      #1;
      if (prev_hold) begin
        chk(out_valid == 1'b1, "R11 valid held under stall", 32'(out_valid), 1);
        chk({out_known, out_is_cmp, out_opf, out_desc, out_fault, out_trap, out_rs1, out_rs2, out_rd} == snap,
            "R11 record stable under stall",
            32'({out_known, out_is_cmp, out_opf, out_desc, out_fault, out_trap, out_rs1, out_rs2, out_rd}),
            32'(snap));
      end
      chk(in_ready == (!out_valid || out_ready), "R11 in_ready rule", 32'(in_ready),
          32'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(0, "R11 unexpected output", 1, 0);
        else begin
          e = q.pop_front();
          chk(out_known == e.known, "R1 known", 32'(out_known), 32'(e.known));
          chk(out_opf == e.opf, "R2 opf", 32'(out_opf), 32'(e.opf));
          chk(out_desc == e.desc, "R3 descriptor", 32'(out_desc), 32'(e.desc));
          chk(out_is_cmp == e.is_cmp, "R6 is_cmp", 32'(out_is_cmp), 32'(e.is_cmp));
          chk({out_fault, out_trap} == {e.fault, e.trap}, "R8 fault/trap",
              32'({out_fault, out_trap}), 32'({e.fault, e.trap}));
          chk({out_rs1, out_rs2, out_rd} == {e.rs1, e.rs2, e.rd}, "R10 indices",
              32'({out_rs1, out_rs2, out_rd}), 32'({e.rs1, e.rs2, e.rd}));
        end
      end
      acc = in_valid && in_ready;
      if (acc) begin
        q.push_back(model(cur));
        have = 0;
        idx++;
      end
      held = in_valid && !acc;
      prev_hold = out_valid && !out_ready;
      snap = {out_known, out_is_cmp, out_opf, out_desc, out_fault, out_trap, out_rs1, out_rs2, out_rd};
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R11 idle after drain", 32'(out_valid), 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule